// File: doc/BRIEF.md
# Regulator fault counting supervisor

This block watches the fault flags of a group of power rails and decides which rails must be turned off and when the whole group must be shut down. Undervoltage on any rail, or overcurrent on the memory supply (rail 0), turns off only that rail and adds one to a fault count. A rail that loses its input because an upstream rail was turned off reports its own undervoltage, and that is counted as a separate fault. Overvoltage on the memory supply or on the memory termination rail, over-temperature, or a fault count that reaches its limit shuts down every rail at once.

The fault count is forgiven after a long quiet period. A quiet-time counter advances once per slow tick (a 250 kHz enable), is cleared by every counted fault, and stops at 16384 without wrapping. When it stands at 16384 the fault count drops to zero. The limit is 4 while the system is starting up out of the soft-off state (`from_s5` high) and 5 at all other times. Faulted rails are offered back to the start-up sequencer as restart requests. The sequencer acknowledges each rail it has brought back, and rails that never faulted are left alone.

Top module: `rail_fault_supervisor`

## Requirements
- R1: After reset, `rail_kill`, `restart_req`, `shutdown` and `fault_count` are all zero.
- R2: A rising edge on `uv_flag[i]`, or on `oc_mem` for rail 0, sets `rail_kill[i]` two clock edges after it is sampled and touches no other rail. A flag held high is counted only once.
- R3: Rails that fault in the same cycle are counted one per clock, in order from rail 0 upward. `fault_count` grows by exactly one per step and saturates at 7.
- R4: The quiet-time counter advances on each edge with `tick` high, is cleared by every counted fault, and holds at 16384. While it holds at 16384, `fault_count` is zero.
- R5: `shutdown` rises one edge after `fault_count` reaches 4 with `from_s5` high, or 5 with `from_s5` low. A count below the limit leaves `shutdown` low.
- R6: A high level on `ov_mem` or `ov_term` sets `shutdown`. It stays set until `s5_n` has been low and then returns high.
- R7: `temp_hot` sets `shutdown`. It clears only when `temp_cool` is high together with a `bias_por` pulse or a low-to-high return of `s5_n`. A `bias_por` pulse while `temp_cool` is low has no effect.
- R8: `restart_req` equals the set of individually faulted rails while `shutdown` is low, and is zero while `shutdown` is high. `restart_ack[i]` clears only rail i. While `shutdown` is high, `rail_kill` is all ones.
- R9: While `s5_n` is sampled low, the fault count, the pending faults and the per-rail disables are cleared. The latched shutdown causes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow time-base enable for the quiet-time counter |
| uv_flag | input | RAILS | Per-rail undervoltage flags |
| oc_mem | input | 1 | Overcurrent on the memory supply (rail 0) |
| ov_mem | input | 1 | Overvoltage on the memory supply |
| ov_term | input | 1 | Overvoltage on the memory termination rail |
| temp_hot | input | 1 | Die temperature at or above the trip point |
| temp_cool | input | 1 | Die temperature below the recovery point |
| bias_por | input | 1 | Bias power-on-reset pulse |
| s5_n | input | 1 | Soft-off state request, active low |
| from_s5 | input | 1 | High while starting up out of soft-off |
| restart_ack | input | RAILS | Sequencer has restarted rail i |
| rail_kill | output | RAILS | Per-rail disable |
| restart_req | output | RAILS | Rails awaiting restart by the sequencer |
| shutdown | output | 1 | Global shutdown latch |
| fault_count | output | CW | Current fault count |

## Verification
The bench makes several rails fault in the same cycle and checks that each one adds exactly one to the count. A design that merged simultaneous faults would undercount and miss its trip. It holds flags high for a long time to catch a count that repeats on a level instead of an edge. It also lets the quiet window run both part way and all the way, which exposes a counter that wraps or forgives too early. Both trip limits are exercised, one with `from_s5` high and one with it low; a design that swapped them would shut down one fault early or late. Finally, the bench tries a power-on-reset pulse while the die is still hot, and holds `s5_n` low for several cycles without releasing it. A latch that cleared on the wrong event would release `shutdown` early.

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int RAILS = 5,
  parameter int FORGIVE = 16384,
  parameter int LIMIT_S5 = 4,
  parameter int LIMIT_RUN = 5,
  localparam int CW = $clog2(LIMIT_RUN + 1),
  localparam int QW = $clog2(FORGIVE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [RAILS-1:0] uv_flag,
  input  logic             oc_mem,
  input  logic             ov_mem,
  input  logic             ov_term,
  input  logic             temp_hot,
  input  logic             temp_cool,
  input  logic             bias_por,
  input  logic             s5_n,
  input  logic             from_s5,
  input  logic [RAILS-1:0] restart_ack,
  output logic [RAILS-1:0] rail_kill,
  output logic [RAILS-1:0] restart_req,
  output logic             shutdown,
  output logic [CW-1:0]    fault_count
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [QW-1:0] QFULL = QW'(FORGIVE);

  logic [RAILS-1:0] fq, fqd, pend, off;
  logic [QW-1:0] quiet;
  logic s5q, s5qd, ovq, hotq, coolq, porq, froms5q;
  logic ov_lat, ot_lat, trip_lat;

  wire [RAILS-1:0] rise  = fq & ~fqd;
  wire [RAILS-1:0] grant = pend & (~pend + 1'b1);
  wire             s5_rise = s5q & ~s5qd;
  wire [CW-1:0]    limit = froms5q ? CW'(LIMIT_S5) : CW'(LIMIT_RUN);

  assign shutdown    = ov_lat | ot_lat | trip_lat;
  assign rail_kill   = off | {RAILS{shutdown}};
  assign restart_req = off & ~{RAILS{shutdown}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fq <= '0; fqd <= '0; pend <= '0; off <= '0;
      quiet <= '0; fault_count <= '0;
      s5q <= 1'b0; s5qd <= 1'b0; ovq <= 1'b0; hotq <= 1'b0;
      coolq <= 1'b0; porq <= 1'b0; froms5q <= 1'b0;
      ov_lat <= 1'b0; ot_lat <= 1'b0; trip_lat <= 1'b0;
    end else begin
      fq      <= uv_flag | {{(RAILS-1){1'b0}}, oc_mem};
      fqd     <= fq;
      s5q     <= s5_n;
      s5qd    <= s5q;
      ovq     <= ov_mem | ov_term;
      hotq    <= temp_hot;
      coolq   <= temp_cool;
      porq    <= bias_por;
      froms5q <= from_s5;

      ov_lat   <= ovq | (ov_lat & ~s5_rise);
      ot_lat   <= hotq | (ot_lat & ~(coolq & (porq | s5_rise)));
      trip_lat <= (fault_count >= limit) | (trip_lat & ~s5_rise);

      if (!s5q) begin
        pend <= '0; off <= '0; fault_count <= '0; quiet <= '0;
      end else begin
        pend <= (pend & ~grant) | rise;
        off  <= (off & ~restart_ack) | rise;
        if (|grant) begin
          quiet <= '0;
          if (fault_count != CMAX) fault_count <= fault_count + 1'b1;
        end else begin
          if (quiet == QFULL) fault_count <= '0;
          if (tick && quiet != QFULL) quiet <= quiet + 1'b1;
        end
      end
    end
  end

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_count != $past(fault_count) |->
      (fault_count == CW'($past(fault_count) + 1'b1) || fault_count == '0));

  assert_forgiven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet == QFULL && $past(quiet) == QFULL) |-> fault_count == '0);

  assert_no_quiet_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet <= QFULL);

  assert_trip_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_count >= CW'(LIMIT_RUN) |=> shutdown);

  assert_ov_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ov_lat) |-> $past(s5q && !s5qd));

  assert_cool_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_lat) |-> $past(coolq));

  assert_req_quiet_in_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> restart_req == '0 && rail_kill == '1);
endmodule

// File: tb/tb_rail_fault_supervisor.sv
module tb_rail_fault_supervisor;
  localparam int N = 5;
  localparam int F = 16384;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [N-1:0] uv_flag = '0, restart_ack = '0;
  logic oc_mem = 0, ov_mem = 0, ov_term = 0, temp_hot = 0, temp_cool = 0;
  logic bias_por = 0, s5_n = 1, from_s5 = 0;
  logic [N-1:0] rail_kill, restart_req;
  logic shutdown;
  logic [2:0] fault_count;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rail_fault_supervisor dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_flag(uv_flag), .oc_mem(oc_mem),
    .ov_mem(ov_mem), .ov_term(ov_term), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .bias_por(bias_por), .s5_n(s5_n), .from_s5(from_s5), .restart_ack(restart_ack),
    .rail_kill(rail_kill), .restart_req(restart_req), .shutdown(shutdown),
    .fault_count(fault_count));

  // behavioural reference: sampled inputs, a pending-fault queue, integer counters
  bit smp_f[N], smp_fd[N], m_off[N];
  int queue_q[$];
  int m_cnt, m_quiet;
  bit s_s5, s_s5d, s_ov, s_hot, s_cool, s_por, s_from;
  bit m_ov, m_ot, m_trip;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (smp_f[i]) begin smp_f[i] = 0; smp_fd[i] = 0; m_off[i] = 0; end
      queue_q.delete();
      m_cnt = 0; m_quiet = 0;
      {s_s5, s_s5d, s_ov, s_hot, s_cool, s_por, s_from} = '0;
      {m_ov, m_ot, m_trip} = '0;
    end else begin
      bit new_rise[N];
      bit served;
      bit s5r;
      int lim;
      served = 0;
      s5r = s_s5 && !s_s5d;
      lim = s_from ? 4 : 5;
      foreach (new_rise[i]) new_rise[i] = smp_f[i] && !smp_fd[i];
      m_trip = (m_cnt >= lim) || (m_trip && !s5r);
      m_ov = s_ov || (m_ov && !s5r);
      m_ot = s_hot || (m_ot && !(s_cool && (s_por || s5r)));
      if (!s_s5) begin
        queue_q.delete();
        foreach (m_off[i]) m_off[i] = 0;
        m_cnt = 0; m_quiet = 0;
      end else begin
        if (queue_q.size() > 0) begin
          void'(queue_q.pop_front());
          served = 1;
        end
        for (int i = 0; i < N; i++) begin
          if (new_rise[i]) begin
            bit found;
            found = 0;
            foreach (queue_q[k]) if (queue_q[k] == i) found = 1;
            if (!found) queue_q.push_back(i);
            queue_q.sort();
          end
          m_off[i] = new_rise[i] || (m_off[i] && !restart_ack[i]);
        end
        if (served) begin
          m_quiet = 0;
          if (m_cnt < 7) m_cnt++;
        end else begin
          if (m_quiet == F) m_cnt = 0;
          if (tick && m_quiet < F) m_quiet++;
        end
      end
      for (int i = 0; i < N; i++) begin
        smp_fd[i] = smp_f[i];
        smp_f[i] = uv_flag[i] || (i == 0 && oc_mem);
      end
      s_s5d = s_s5; s_s5 = s5_n; s_ov = ov_mem || ov_term; s_hot = temp_hot;
      s_cool = temp_cool; s_por = bias_por; s_from = from_s5;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ek, er;
      bit sd;
      sd = m_ov || m_ot || m_trip;
      ek = 0; er = 0;
      for (int i = 0; i < N; i++) begin
        if (m_off[i] || sd) ek |= (1 << i);
        if (m_off[i] && !sd) er |= (1 << i);
      end
      chk(rail_kill, ek, "R2 model rail_kill");
      chk(restart_req, er, "R8 model restart_req");
      chk(shutdown, sd, "R5 model shutdown");
      chk(fault_count, m_cnt, "R3 model fault_count");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic s5_cycle();
    s5_n = 0; step(4); s5_n = 1; step(4);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk(rail_kill, 0, "R1 kill after reset");
    chk(shutdown, 0, "R1 shutdown after reset");
    chk(fault_count, 0, "R1 count after reset");
    step(4);

    uv_flag = 5'b00100; step(6);
    chk(rail_kill, 5'b00100, "R2 only rail 2 off");
    chk(fault_count, 1, "R2 single count");
    step(40);
    chk(fault_count, 1, "R2 held level counted once");
    uv_flag = '0; step(2);
    restart_ack = 5'b00100; step(1); restart_ack = '0; step(2);
    chk(restart_req, 0, "R8 ack clears rail 2");

    uv_flag = 5'b01011; step(3);
    chk(fault_count, 2, "R3 one per clock");
    step(4);
    chk(fault_count, 4, "R3 three simultaneous faults");
    chk(restart_req, 5'b01011, "R8 requests faulted rails");
    chk(shutdown, 0, "R5 count 4 below running limit");
    uv_flag = '0;
    restart_ack = 5'b00010; step(1); restart_ack = '0; step(2);
    chk(restart_req, 5'b01001, "R8 ack leaves other rails");
    step(10000);
    chk(fault_count, 4, "R4 not yet forgiven");
    step(6500);
    chk(fault_count, 0, "R4 forgiven after quiet window");
    restart_ack = '1; step(1); restart_ack = '0; step(2);

    uv_flag = '1; step(10);
    chk(fault_count, 5, "R5 five faults counted");
    chk(shutdown, 1, "R5 running limit trips");
    chk(restart_req, 0, "R8 no requests in shutdown");
    uv_flag = '0; step(2);
    s5_n = 0; step(4);
    chk(fault_count, 0, "R9 count cleared in soft-off");
    chk(shutdown, 1, "R9 latch kept while low");
    s5_n = 1; step(4);
    chk(shutdown, 0, "R9 cleared after return");
    chk(rail_kill, 0, "R9 rails cleared");

    from_s5 = 1; step(2);
    uv_flag = 5'b01111; step(9);
    chk(shutdown, 1, "R5 start limit trips at 4");
    uv_flag = '0; step(2); s5_cycle(); from_s5 = 0;
    chk(shutdown, 0, "R5 cleared after soft-off");

    ov_term = 1; step(1); ov_term = 0; step(4);
    chk(shutdown, 1, "R6 termination overvoltage");
    step(50);
    chk(shutdown, 1, "R6 latch holds");
    s5_n = 0; step(4);
    chk(shutdown, 1, "R6 held while soft-off low");
    s5_n = 1; step(4);
    chk(shutdown, 0, "R6 released on return");
    ov_mem = 1; step(1); ov_mem = 0; step(4);
    chk(shutdown, 1, "R6 memory overvoltage");
    s5_cycle();
    chk(shutdown, 0, "R6 released again");

    temp_hot = 1; step(2); temp_hot = 0; step(4);
    chk(shutdown, 1, "R7 over-temperature");
    bias_por = 1; step(1); bias_por = 0; step(4);
    chk(shutdown, 1, "R7 por while hot ignored");
    temp_cool = 1; step(2);
    bias_por = 1; step(1); bias_por = 0; step(4);
    chk(shutdown, 0, "R7 por after cooling clears");
    temp_cool = 0;

    oc_mem = 1; step(6);
    chk(rail_kill, 5'b00001, "R2 overcurrent disables rail 0");
    oc_mem = 0; step(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule